// File: doc/BRIEF.md
# PRBS-Driven QPSK Symbol Source

This block produces an endless stream of QPSK test symbols for feeding a transform or modem datapath. A 16-bit linear feedback shift register produces a pseudo-random bit stream. Each pair of bits sets the signs of the two components of a Gray-coded 4-point constellation with unit average power. The point leaves the block as one 32-bit word that holds two quantized components, each with 11 fractional bits.

The output uses a valid/ready handshake with a registered output stage. `en_i` tells the block whether to offer a further symbol once the current one has been taken. A frame marker flags every 64th symbol, so a downstream consumer can block the stream into fixed-length transforms.

Top module: `qpsk_prbs_src`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0. Reset loads the shift register with all ones and clears the frame count. The first symbol after reset is therefore 32'h05A8_05A8.
- R2: Take shift register positions 1..16 as bits 0..15. Each step forms a feedback bit as the XOR of positions 11, 13, 14 and 16. It then shifts the register one place toward the higher positions and puts the feedback bit into position 1. The stream bit for that step is the feedback bit.
- R3: Every symbol uses two consecutive stream bits. The earlier bit sets the sign of the real part and the later bit sets the sign of the imaginary part. A bit value of 0 gives a positive component and 1 gives a negative one.
- R4: Each component has magnitude 1448. This is 2^11/sqrt(2) rounded to the nearest integer and clamped to the range -2048..2047.
- R5: `data_o[31:16]` holds the imaginary part and `data_o[15:0]` holds the real part, each in two's complement and sign-extended from 12 to 16 bits.
- R6: The shift register moves on only when a symbol is loaded into the output stage. While `valid_o` is 1 and `ready_i` is 0, `valid_o`, `data_o` and `last_o` stay unchanged.
- R7: `last_o` is 1 on the 64th, 128th, ... symbol after reset and 0 on all other symbols.
- R8: At a clock edge where the output stage is empty or its symbol is being taken, the next state of `valid_o` is `en_i`. No stream bits are used when `en_i` is 0, so the sequence resumes without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allow a further symbol to be offered |
| ready_i | input | 1 | Consumer accepts the current symbol |
| valid_o | output | 1 | A symbol is on `data_o` |
| data_o | output | 32 | Imaginary part in [31:16], real part in [15:0] |
| last_o | output | 1 | Marks the final symbol of a 64-symbol frame |

## Verification
The assertions assume a consumer that may hold `ready_i` low for any length of time and may toggle `en_i` in any cycle. Under those inputs only the hold rule and the load rule bind the output. The frame assertion counts accepted symbols itself, so it relies on reset being the only point where the frame count restarts. The stimulus covers free-running transfer, irregular back-pressure, enable gaps that land both on a stalled symbol and on an empty stage, and a reset in the middle of a frame followed by a return to the seed sequence.

// File: rtl/qpsk_src_pkg.sv
package qpsk_src_pkg;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
  // feedback positions 16,14,13,11 -> bits 15,13,12,10
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  localparam int unsigned BITS_PER_SYM = 2;
  localparam int unsigned Q_W     = 12;
  localparam int unsigned FRAC_W  = 11;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned WORD_W  = 2 * FIELD_W;
  localparam int unsigned FRAME_LEN = 64;

  localparam int Q_MAX = (1 << (Q_W - 1)) - 1;
  localparam int Q_MIN = -(1 << (Q_W - 1));

  // nearest-integer square root
  function automatic int isqrt_round(input int v);
    int a;
    int t;
    a = 0;
    for (int b = 15; b >= 0; b--) begin
      t = a | (1 << b);
      if (t * t <= v) a = t;
    end
    if (v - a * a > a) a = a + 1;
    return a;
  endfunction

  function automatic int clamp_q(input int v);
    if (v > Q_MAX) return Q_MAX;
    if (v < Q_MIN) return Q_MIN;
    return v;
  endfunction

  // (2^FRAC)^2 / 2 under the root gives 2^FRAC / sqrt(2)
  localparam int AMP = clamp_q(isqrt_round(1 << (2 * FRAC_W - 1)));

  typedef struct packed {
    logic signed [FIELD_W-1:0] im;
    logic signed [FIELD_W-1:0] re;
  } cplx_word_t;

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int unsigned       W     = 16,
  parameter logic [W-1:0]      TAPS  = 16'hB400,
  parameter logic [W-1:0]      SEED  = '1,
  parameter int unsigned       STEPS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [STEPS-1:0] bits_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] stage [STEPS+1];

  assign stage[0] = state_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb            = ^(stage[g] & TAPS);
    assign stage[g+1]    = {stage[g][W-2:0], fb};
    assign bits_o[g]     = fb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= stage[STEPS];
  end

endmodule

// File: rtl/qpsk_mapper.sv
module qpsk_mapper
  import qpsk_src_pkg::*;
(
  input  logic [BITS_PER_SYM-1:0] bits_i,
  output cplx_word_t              word_o
);

  localparam logic signed [FIELD_W-1:0] POS = FIELD_W'(AMP);
  localparam logic signed [FIELD_W-1:0] NEG = -POS;

  // earlier bit -> real sign, later bit -> imaginary sign; 1 means negative
  always_comb begin
    word_o.re = bits_i[0] ? NEG : POS;
    word_o.im = bits_i[1] ? NEG : POS;
  end

endmodule

// File: rtl/frame_ctr.sv
module frame_ctr #(
  parameter int unsigned LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic wrap_o
);

  localparam int unsigned CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/qpsk_prbs_src.sv
module qpsk_prbs_src
  import qpsk_src_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              last_o
);

  logic [BITS_PER_SYM-1:0] sym_bits;
  cplx_word_t              sym_word;
  logic                    frame_wrap;
  logic                    load;
  logic                    take;

  logic              valid_q;
  logic [WORD_W-1:0] data_q;
  logic              last_q;

  // output stage refills when empty or when its symbol leaves
  assign load = !valid_q || ready_i;
  assign take = load && en_i;

  prbs_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED),
    .STEPS(BITS_PER_SYM)
  ) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (take),
    .bits_o(sym_bits)
  );

  qpsk_mapper u_map (
    .bits_i(sym_bits),
    .word_o(sym_word)
  );

  frame_ctr #(
    .LEN(FRAME_LEN)
  ) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(take),
    .wrap_o(frame_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (load) begin
      valid_q <= en_i;
      if (en_i) begin
        data_q <= sym_word;
        last_q <= frame_wrap;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

endmodule

// File: rtl/qpsk_prbs_src_chk.sv
module qpsk_prbs_src_chk
  import qpsk_src_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              ready_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] data_o,
  input logic              last_o
);

  localparam int unsigned CW = $clog2(FRAME_LEN);
  localparam logic [FIELD_W-1:0] P = FIELD_W'(AMP);
  localparam logic [FIELD_W-1:0] N = FIELD_W'(-AMP);

  logic [CW-1:0] acc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_cnt <= '0;
    else if (valid_o && ready_i) acc_cnt <= acc_cnt + 1'b1;
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

  a_r4_re_mag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o[FIELD_W-1:0] == P) || (data_o[FIELD_W-1:0] == N));

  a_r5_im_mag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o[WORD_W-1:FIELD_W] == P) || (data_o[WORD_W-1:FIELD_W] == N));

  a_r7_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> last_o == (acc_cnt == CW'(FRAME_LEN - 1)));

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && (!valid_o || ready_i) |=> !valid_o);

  a_r8_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(en_i));

endmodule

bind qpsk_prbs_src qpsk_prbs_src_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .ready_i(ready_i),
  .valid_o(valid_o),
  .data_o (data_o),
  .last_o (last_o)
);

// File: tb/qpsk_prbs_src_tb_top.sv
module qpsk_prbs_src_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RUN_CYCLES = 1600;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        valid_o;
  logic [31:0] data_o;
  logic        last_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  qpsk_prbs_src dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .ready_i(ready_i),
    .valid_o(valid_o),
    .data_o (data_o),
    .last_o (last_o)
  );

  // reference state
  logic [15:0] m_lfsr;
  bit          m_valid;
  logic [31:0] m_data;
  bit          m_last;
  int          m_sym;
  int          accepted;
  bit          fresh;

  function automatic bit next_bit(ref logic [15:0] r);
    bit fb;
    fb = r[10] ^ r[12] ^ r[13] ^ r[15];
    r  = {r[14:0], fb};
    return fb;
  endfunction

  function automatic logic [31:0] make_word(bit b_re, bit b_im);
    int re, im;
    re = b_re ? -1448 : 1448;
    im = b_im ? -1448 : 1448;
    return {16'(im), 16'(re)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lfsr = 16'hFFFF;
    m_valid = 0;
    m_sym = 0;
    m_last = 0;
    fresh = 1;
  endtask

  initial begin : main
    bit p_en, p_rdy, p_rst;
    bit p_stall;
    logic [31:0] p_data;
    bit p_last_out;
    bit b0, b1;
    bit n_en, n_rdy, n_rst;
    p_en = 0; p_rdy = 0; p_rst = 0; p_stall = 0; p_data = '0; p_last_out = 0;
    accepted = 0;
    model_reset();
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk_i);
      // update model for the edge just passed
      if (!p_rst) begin
        model_reset();
      end else begin
        if (m_valid && p_rdy) accepted++;
        if (!m_valid || p_rdy) begin
          if (p_en) begin
            b0 = next_bit(m_lfsr);
            b1 = next_bit(m_lfsr);
            m_data = make_word(b0, b1);
            m_last = (m_sym % 64) == 63;
            m_sym++;
            m_valid = 1;
          end else begin
            m_valid = 0;
          end
        end
      end
      // compare
      if (!rst_ni) begin
        check(valid_o == 1'b0, "R1 valid in reset", 32'(valid_o), 32'd0);
      end else begin
        check(valid_o == m_valid, "R8 valid", 32'(valid_o), 32'(m_valid));
        if (p_stall) begin
          check(valid_o && data_o == p_data && last_o == p_last_out, "R6 hold",
                data_o, p_data);
        end
        if (m_valid && valid_o) begin
          if (fresh) begin
            check(data_o == 32'h05A8_05A8, "R1 first symbol", data_o, 32'h05A8_05A8);
            fresh = 0;
          end
          check(data_o == m_data, "R2/R3 symbol", data_o, m_data);
          check(last_o == m_last, "R7 last", 32'(last_o), 32'(m_last));
          check((data_o[15:0] == 16'h05A8 || data_o[15:0] == 16'hFA58) &&
                (data_o[31:16] == 16'h05A8 || data_o[31:16] == 16'hFA58),
                "R4 magnitude", data_o, m_data);
          check(data_o[15:11] == {5{data_o[11]}} && data_o[31:27] == {5{data_o[27]}},
                "R5 sign extension", data_o, m_data);
        end
      end
      // drive next inputs
      n_rst = !(cyc < 3 || (cyc >= 1200 && cyc < 1203));
      if (cyc < 400) begin
        n_en = 1; n_rdy = 1;
      end else if (cyc < 1000) begin
        n_en = 1; n_rdy = ((cyc * 13 + cyc / 7) % 5 != 0) && (cyc % 17 != 3);
      end else if (cyc < 1200) begin
        n_en = (cyc / 9) % 3 != 0; n_rdy = (cyc % 4) != 1;
      end else begin
        n_en = 1; n_rdy = (cyc % 23) != 5;
      end
      p_stall    = rst_ni && n_rst && valid_o && !n_rdy;
      p_data     = data_o;
      p_last_out = last_o;
      rst_ni  = n_rst;
      en_i    = n_en;
      ready_i = n_rdy;
      p_rst = n_rst; p_en = n_en; p_rdy = n_rdy;
    end
    // R7 several full frames crossed since the last reset
    check(accepted >= 192 && m_sym >= 192, "R7 frames covered", 32'(m_sym), 32'd192);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule